// File: doc/BRIEF.md
# Windowed Register File

This block is the integer register file of a processor whose general registers are organised as overlapping windows. An instruction names a register with a 5-bit number. The block translates that number into an index of a larger physical array. Register 0 reads as zero. Registers 1 to 7 are shared globals. The upper 24 numbers reach a window of outs, locals and ins, which a current-window pointer selects. The block has two combinational read ports and one clocked write port.

Save and restore requests move the pointer one step around a ring of windows, in opposite directions. The outs of the caller become the ins of the callee, so arguments pass between routines without copying. Software can load an invalid-window mask. When a save or restore would land on a masked window, the pointer stays where it is and the block raises a one-cycle spill or fill trap, which the trap handler services. Within one operation, the sources are read through the window in force before the step and the result is written through the window after it.

Top module: `window_regfile`

## Requirements
- R1: Each port takes a 5-bit register number. Reads on both ports are combinational from the current contents. A write with `wrEn` high takes effect at the rising clock edge.
- R2: Register number 0 always reads as zero on both ports, and a write to it changes no storage.
- R3: Register numbers 1 to 7 refer to the same storage whatever the window pointer holds.
- R4: Register numbers 16 to 23 (locals) are private to each window. Numbers 24 to 31 are the ins of the current window and numbers 8 to 15 are its outs.
- R5: Out k (number 8+k) of window w is the same storage as in k (number 24+k) of window (w-1) mod NWIN, which is the window a save reaches.
- R6: An accepted save sets the pointer to (pointer-1) mod NWIN. An accepted restore sets it to (pointer+1) mod NWIN. When both requests are high in the same cycle, only the save is acted on.
- R7: A save whose target window is marked invalid leaves the pointer unchanged and drops that cycle's write. `spillTrap` is then high for exactly the following cycle. A restore into an invalid window behaves the same way and raises `fillTrap`. The two traps are never high together.
- R8: Mask bit w set to 1 marks window w invalid. `maskWrEn` loads `maskWrData` at the clock edge. A save or restore in that same cycle is judged against the mask as it stood before the load. Reset clears the pointer, the mask and all storage to zero.
- R9: In a cycle with an accepted save or restore, both reads use the old window and the write uses the new window.
- R10: NWIN is a parameter from 3 to 32, and the pointer output always stays below NWIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rdAddrA | input | 5 | Register number for read port A |
| rdDataA | output | DATA_W | Read data for port A |
| rdAddrB | input | 5 | Register number for read port B |
| rdDataB | output | DATA_W | Read data for port B |
| wrEn | input | 1 | Write request |
| wrAddr | input | 5 | Register number to write |
| wrData | input | DATA_W | Write data |
| saveReq | input | 1 | Step the window pointer down |
| restoreReq | input | 1 | Step the window pointer up |
| maskWrEn | input | 1 | Load the invalid-window mask |
| maskWrData | input | NWIN | New invalid-window mask |
| cwp | output | 5 | Current window pointer |
| maskOut | output | NWIN | Current invalid-window mask |
| spillTrap | output | 1 | Save blocked by an invalid target, one cycle |
| fillTrap | output | 1 | Restore blocked by an invalid target, one cycle |

## Verification
The bench builds the block with NWIN = 5 and DATA_W = 16. A window count that is not a power of two shows whether both wrap points of the ring use real modulo arithmetic rather than the natural roll-over of a binary counter. With only five windows, random save and restore runs cross the wrap in both directions many times. They also go back to windows written earlier, so the out/in aliasing and the privacy of locals are checked against old data. Sparse one-hot masks let spill and fill traps happen often, while enough steps are still accepted.

// File: rtl/winrf_pkg.sv
package winrf_pkg;
  localparam int WPTR_W = 5;
  localparam int REGNUM_W = 5;

  typedef logic [WPTR_W-1:0]   wptr_t;
  typedef logic [REGNUM_W-1:0] regnum_t;

  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic  wrCommit;  // write survives trap checks
    wptr_t wrWin;     // window for destination translation
    wptr_t rdWin;     // window for source translation
  } rfStrobe_t;
endpackage

// File: rtl/winrf_ctrl.sv
module winrf_ctrl
  import winrf_pkg::*;
#(
  parameter int NWIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            saveReq,
  input  logic            restoreReq,
  input  logic            wrEn,
  input  logic            maskWrEn,
  input  logic [NWIN-1:0] maskWrData,
  output rfStrobe_t       strobe,
  output wptr_t           cwp,
  output logic [NWIN-1:0] invMask,
  output logic            spillTrap,
  output logic            fillTrap
);
  localparam wptr_t LAST_WIN = wptr_t'(NWIN - 1);

  wptr_t           cwpQ;
  wptr_t           saveTgt;
  wptr_t           restTgt;
  wptr_t           cwpNext;
  logic [NWIN-1:0] maskQ;
  logic [31:0]     maskWide;
  logic            spillHit;
  logic            fillHit;
  logic            doSave;
  logic            doRestore;
  logic            spillQ;
  logic            fillQ;

  // Neighbour windows on the ring, modulo NWIN.
  always_comb begin
    saveTgt = (cwpQ == '0) ? LAST_WIN : cwpQ - wptr_t'(1);
    restTgt = (cwpQ == LAST_WIN) ? '0 : cwpQ + wptr_t'(1);
  end

  assign maskWide = 32'(maskQ);

  // Save takes priority over restore.
  always_comb begin
    spillHit  = saveReq && maskWide[saveTgt];
    fillHit   = !saveReq && restoreReq && maskWide[restTgt];
    doSave    = saveReq && !spillHit;
    doRestore = !saveReq && restoreReq && !fillHit;
    if (doSave)         cwpNext = saveTgt;
    else if (doRestore) cwpNext = restTgt;
    else                cwpNext = cwpQ;
  end

  always_comb begin
    strobe.wrCommit = wrEn && !spillHit && !fillHit;
    strobe.wrWin    = cwpNext;
    strobe.rdWin    = cwpQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwpQ   <= '0;
      maskQ  <= '0;
      spillQ <= 1'b0;
      fillQ  <= 1'b0;
    end else begin
      cwpQ   <= cwpNext;
      spillQ <= spillHit;
      fillQ  <= fillHit;
      if (maskWrEn) maskQ <= maskWrData;
    end
  end

  assign cwp       = cwpQ;
  assign invMask   = maskQ;
  assign spillTrap = spillQ;
  assign fillTrap  = fillQ;
endmodule

// File: rtl/winrf_datapath.sv
module winrf_datapath
  import winrf_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rfStrobe_t         strobe,
  input  regnum_t           rdAddrA,
  input  regnum_t           rdAddrB,
  input  regnum_t           wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);
  localparam int NGLOB     = 8;
  localparam int WIN_SLOTS = 16;
  localparam int NPHYS     = NGLOB + WIN_SLOTS * NWIN;
  localparam int PIDX_W    = $clog2(NPHYS);
  localparam int NRD       = 2;

  typedef logic [PIDX_W-1:0] pidx_t;

  logic [DATA_W-1:0] bank [NPHYS];

  // Per window: slots 0..7 hold the ins, slots 8..15 hold the locals.
  // The outs of window w are the ins of window w-1 on the ring.
  function automatic pidx_t mapReg(regnum_t r, wptr_t w);
    int prevWin;
    int slot;
    prevWin = (w == '0) ? NWIN - 1 : int'(w) - 1;
    case (r[4:3])
      2'd0:    slot = int'(r[2:0]);
      2'd1:    slot = NGLOB + WIN_SLOTS * prevWin + int'(r[2:0]);
      2'd2:    slot = NGLOB + WIN_SLOTS * int'(w) + 8 + int'(r[2:0]);
      default: slot = NGLOB + WIN_SLOTS * int'(w) + int'(r[2:0]);
    endcase
    return pidx_t'(slot);
  endfunction

  regnum_t           rdAddr [NRD];
  logic [DATA_W-1:0] rdData [NRD];

  assign rdAddr[0] = rdAddrA;
  assign rdAddr[1] = rdAddrB;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    pidx_t idx;
    assign idx       = mapReg(rdAddr[p], strobe.rdWin);
    assign rdData[p] = (rdAddr[p] == '0) ? '0 : bank[idx];
  end

  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) bank[i] <= '0;
    end else if (strobe.wrCommit && (wrAddr != '0)) begin
      bank[mapReg(wrAddr, strobe.wrWin)] <= wrData;
    end
  end
endmodule

// File: rtl/window_regfile.sv
module window_regfile
  import winrf_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [4:0]        rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [4:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              saveReq,
  input  logic              restoreReq,
  input  logic              maskWrEn,
  input  logic [NWIN-1:0]   maskWrData,
  output logic [4:0]        cwp,
  output logic [NWIN-1:0]   maskOut,
  output logic              spillTrap,
  output logic              fillTrap
);
  rfStrobe_t strobe;
  wptr_t     cwpInt;

  winrf_ctrl #(.NWIN(NWIN)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .saveReq    (saveReq),
    .restoreReq (restoreReq),
    .wrEn       (wrEn),
    .maskWrEn   (maskWrEn),
    .maskWrData (maskWrData),
    .strobe     (strobe),
    .cwp        (cwpInt),
    .invMask    (maskOut),
    .spillTrap  (spillTrap),
    .fillTrap   (fillTrap)
  );

  winrf_datapath #(.NWIN(NWIN), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .rdAddrA (rdAddrA),
    .rdAddrB (rdAddrB),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdDataA (rdDataA),
    .rdDataB (rdDataB)
  );

  assign cwp = cwpInt;
endmodule

// File: rtl/window_regfile_chk.sv
module window_regfile_chk #(
  parameter int NWIN   = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [4:0]        rdAddrB,
  input logic [DATA_W-1:0] rdDataB,
  input logic              saveReq,
  input logic              restoreReq,
  input logic              maskWrEn,
  input logic [NWIN-1:0]   maskWrData,
  input logic [4:0]        cwp,
  input logic [NWIN-1:0]   maskOut,
  input logic              spillTrap,
  input logic              fillTrap
);
  logic [4:0]  downWin;
  logic [4:0]  upWin;
  logic [31:0] maskWide;

  assign downWin  = (cwp == 5'd0) ? 5'(NWIN - 1) : cwp - 5'd1;
  assign upWin    = (cwp == 5'(NWIN - 1)) ? 5'd0 : cwp + 5'd1;
  assign maskWide = 32'(maskOut);

  assert_zero_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdAddrA == 5'd0) |-> (rdDataA == '0));
  assert_zero_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdAddrB == 5'd0) |-> (rdDataB == '0));

  assert_save_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (saveReq && !maskWide[downWin]) |=> (cwp == $past(downWin)));
  assert_restore_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!saveReq && restoreReq && !maskWide[upWin]) |=> (cwp == $past(upWin)));

  assert_spill_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    spillTrap |-> (cwp == $past(cwp) && $past(saveReq)));
  assert_fill_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fillTrap |-> (cwp == $past(cwp) && $past(restoreReq)));
  assert_trap_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(spillTrap && fillTrap));

  assert_mask_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    maskWrEn |=> (maskOut == $past(maskWrData)));

  assert_cwp_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cwp) < NWIN));
endmodule

bind window_regfile window_regfile_chk #(.NWIN(NWIN), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rdAddrA    (rdAddrA),
  .rdDataA    (rdDataA),
  .rdAddrB    (rdAddrB),
  .rdDataB    (rdDataB),
  .saveReq    (saveReq),
  .restoreReq (restoreReq),
  .maskWrEn   (maskWrEn),
  .maskWrData (maskWrData),
  .cwp        (cwp),
  .maskOut    (maskOut),
  .spillTrap  (spillTrap),
  .fillTrap   (fillTrap)
);

// File: tb/window_regfile_bench.sv
module window_regfile_bench;
  localparam int NW = 5;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [DW-1:0] rdDataA, rdDataB, wrData = '0;
  logic          wrEn = 1'b0, saveReq = 1'b0, restoreReq = 1'b0, maskWrEn = 1'b0;
  logic [NW-1:0] maskWrData = '0;
  logic [4:0]    cwp;
  logic [NW-1:0] maskOut;
  logic          spillTrap, fillTrap;

  always #4 clk = ~clk;

  window_regfile #(.NWIN(NW), .DATA_W(DW)) u_window_regfile (
    .clk(clk), .rst_n(rst_n),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .saveReq(saveReq), .restoreReq(restoreReq),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .cwp(cwp), .maskOut(maskOut), .spillTrap(spillTrap), .fillTrap(fillTrap)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Reference model built from the requirements.
  logic [DW-1:0] glob [8];
  logic [DW-1:0] insM [NW][8];
  logic [DW-1:0] locM [NW][8];
  int            cwpM = 0;
  logic [NW-1:0] maskM = '0;
  bit            expSpill = 0, expFill = 0;

  function automatic logic [DW-1:0] modelRead(int r, int w);
    if (r == 0)       return '0;
    else if (r < 8)   return glob[r];
    else if (r < 16)  return insM[(w + NW - 1) % NW][r - 8];
    else if (r < 24)  return locM[w][r - 16];
    else              return insM[w][r - 24];
  endfunction

  task automatic modelWrite(int r, int w, logic [DW-1:0] v);
    if (r == 0)       return;
    else if (r < 8)   glob[r] = v;
    else if (r < 16)  insM[(w + NW - 1) % NW][r - 8] = v;
    else if (r < 24)  locM[w][r - 16] = v;
    else              insM[w][r - 24] = v;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One clock of stimulus with checks of state and reads.
  task automatic step(bit sv, bit rs, bit we, int wa, logic [DW-1:0] wd,
                      bit mwe, logic [NW-1:0] md, int ra, int rb, string tag);
    int tgtS, tgtR, nw;
    bit spl, fil;
    @(negedge clk);
    check("R6 pointer", 32'(cwp), 32'(cwpM));
    check("R8 mask", 32'(maskOut), 32'(maskM));
    check("R7 spill", 32'(spillTrap), 32'(expSpill));
    check("R7 fill", 32'(fillTrap), 32'(expFill));
    saveReq = sv; restoreReq = rs; wrEn = we; wrAddr = 5'(wa); wrData = wd;
    maskWrEn = mwe; maskWrData = md; rdAddrA = 5'(ra); rdAddrB = 5'(rb);
    #1;
    check(tag, 32'(rdDataA), 32'(modelRead(ra, cwpM)));
    check(tag, 32'(rdDataB), 32'(modelRead(rb, cwpM)));
    tgtS = (cwpM + NW - 1) % NW;
    tgtR = (cwpM + 1) % NW;
    spl = sv && maskM[tgtS];
    fil = !sv && rs && maskM[tgtR];
    nw = cwpM;
    if (sv && !spl) nw = tgtS;
    else if (!sv && rs && !fil) nw = tgtR;
    if (we && !spl && !fil) modelWrite(wa, nw, wd);
    if (mwe) maskM = md;
    expSpill = spl;
    expFill = fil;
    cwpM = nw;
  endtask

  task automatic idle(int ra, int rb, string tag);
    step(0, 0, 0, 0, '0, 0, '0, ra, rb, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd2024);
    for (int i = 0; i < 8; i++) glob[i] = '0;
    for (int w = 0; w < NW; w++)
      for (int k = 0; k < 8; k++) begin
        insM[w][k] = '0;
        locM[w][k] = '0;
      end

    // Reset state (R8).
    rdAddrA = 5'd9; rdAddrB = 5'd20;
    repeat (3) @(negedge clk);
    check("R8 reset cwp", 32'(cwp), 32'd0);
    check("R8 reset mask", 32'(maskOut), 32'd0);
    check("R8 reset spill", 32'(spillTrap), 32'd0);
    check("R8 reset fill", 32'(fillTrap), 32'd0);
    check("R8 reset data", 32'(rdDataA), 32'd0);
    rst_n = 1'b1;

    // Globals and register 0.
    step(0, 0, 1, 3, 16'hA1A1, 0, '0, 0, 0, "R1");
    step(0, 0, 1, 0, 16'hFFFF, 0, '0, 3, 0, "R3 global");
    idle(0, 3, "R2 zero reg");
    // Out o2 and local l1 in window 0.
    step(0, 0, 1, 10, 16'hB2B2, 0, '0, 0, 0, "R1");
    step(0, 0, 1, 17, 16'hC3C3, 0, '0, 10, 0, "R1");
    // Save wraps 0 -> 4.
    step(1, 0, 0, 0, '0, 0, '0, 17, 10, "R9 old window");
    idle(26, 17, "R5 out becomes in");
    idle(3, 0, "R3 global after save");
    idle(17, 16, "R4 private locals");
    // Save with write in the same cycle: write lands in window 3.
    step(1, 0, 1, 16, 16'hD4D4, 0, '0, 26, 16, "R9 read before step");
    idle(16, 24, "R9 write through new window");
    step(0, 1, 0, 0, '0, 0, '0, 16, 0, "R6 restore");
    idle(16, 26, "R9 old window untouched");
    step(0, 1, 0, 0, '0, 0, '0, 0, 0, "R6 restore wrap");
    idle(17, 10, "R4 locals kept");
    // Both requests: save wins (0 -> 4).
    step(1, 1, 0, 0, '0, 0, '0, 0, 0, "R6 both requests");
    // Mark window 3 invalid, then save from 4 with a write.
    step(0, 0, 0, 0, '0, 1, NW'(5'b01000), 0, 0, "R8 mask load");
    step(1, 0, 1, 5, 16'h7777, 0, '0, 0, 0, "R7 spill");
    idle(5, 0, "R7 dropped write");
    idle(5, 0, "R7 one cycle");
    // Mark window 0 invalid, restore from 4 traps.
    step(0, 0, 0, 0, '0, 1, NW'(5'b00001), 0, 0, "R8 mask load");
    step(0, 1, 1, 6, 16'h6666, 0, '0, 0, 0, "R7 fill");
    idle(6, 0, "R7 dropped write");
    // Mask load in the same cycle as a save: old mask is used.
    step(1, 0, 0, 0, '0, 1, NW'(5'b01000), 0, 0, "R8 old mask used");
    idle(0, 0, "R8 old mask used");
    step(0, 0, 0, 0, '0, 1, '0, 0, 0, "R8 mask clear");

    // Constrained random traffic.
    for (int n = 0; n < 3000; n++) begin
      int op;
      bit sv, rs, mwe;
      logic [NW-1:0] md;
      op  = int'($urandom % 16);
      sv  = (op < 4) || (op == 8);
      rs  = (op >= 4 && op < 9);
      mwe = ($urandom % 20) == 0;
      md  = (($urandom % 3) == 0) ? '0 : NW'(1) << ($urandom % NW);
      step(sv, rs, bit'($urandom % 2), int'($urandom % 32), 16'($urandom),
           mwe, md, int'($urandom % 32), int'($urandom % 32), "R1 random");
    end
    idle(0, 0, "R10 final");
    idle(0, 0, "R10 final");

    finished = 1;
    summary();
    $finish;
  end
endmodule